// File: doc/BRIEF.md
# Parallel EEPROM Page Writer with Completion Polling

This block is a host-side bus master for a byte-wide parallel EEPROM. The host asks for a page write by presenting a base address and a byte count on a valid/ready start port. It then streams the bytes on a second valid/ready port. For each byte the block produces one write-strobe pulse on the memory's active-low chip-enable, write-enable and output-enable lines, and it drives the address bus and the data bus.

All bytes of one request stay in the page selected by the upper address bits. The low address bits step upward from the base and wrap inside the page. When the final byte has been written, the block keeps that byte's address and data. After a bus turnaround it reads the kept address over and over. Each read compares bit 7 of the returned value with bit 7 of the kept data. A match means the device has finished its internal programming, and the block raises a one-clock done pulse. If a set number of reads pass without a match, it raises a one-clock timeout pulse instead. In both cases it returns to idle.

The bidirectional data bus is brought out as three parts: an output value, an output enable and an input value. The pad ring joins them.

Top module: `eeprom_page_poller`

## Requirements
- R1: After reset, CE, WE and OE are all high, the data-bus enable is low, start_ready is high and done and timeout_err are low.
- R2: A start request is taken only while start_ready is high. While a page write or its polling is in progress, start_ready is low and start_valid has no effect on the bus sequence.
- R3: A request with length field L writes exactly L+1 bytes (1 to PAGE_BYTES). Byte i goes to the address formed by keeping the base address bits above the page offset and setting the offset to (base offset + i) modulo PAGE_BYTES. So address bits 14 down to 7 never change within one request.
- R4: Each byte produces a single WE pulse of exactly WE_LOW_CLKS clocks with CE low. Address and data are stable and driven from one clock before the falling edge through the clock in which WE returns high.
- R5: The data-bus enable is high only during write pulses and never while OE is low. At least one clock with the enable low and CE high comes before every OE falling edge.
- R6: Each poll read holds CE and OE low and WE high for READ_CLKS clocks at the address of the last byte written. Consecutive reads are separated by one clock with CE and OE high.
- R7: When bit 7 of a poll read equals bit 7 of the last byte written, done pulses for one clock, no further read is issued and start_ready returns high.
- R8: If MAX_POLLS reads complete without a bit-7 match, timeout_err pulses for one clock, no further read is issued and the block returns to idle. A match on read number MAX_POLLS reports done, not timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Page write request |
| start_ready | output | 1 | High while idle and able to accept a request |
| start_addr | input | ADDR_W | Base address of the page write |
| start_len_m1 | input | log2(PAGE_BYTES) | Number of bytes minus one |
| byte_valid | input | 1 | Next data byte available |
| byte_ready | output | 1 | Block is waiting for the next byte |
| byte_data | input | DATA_W | Data byte |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_dq_out | output | DATA_W | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus output enable |
| mem_dq_in | input | DATA_W | Value read from the data bus |
| done | output | 1 | One-clock pulse: programming finished |
| timeout_err | output | 1 | One-clock pulse: poll limit reached without completion |

## Verification
Two events can land on the same read: the bit-7 match that ends polling and the poll counter reaching its limit. The bench provokes this with an EEPROM model that stays busy for exactly MAX_POLLS-1 reads, so that the final permitted read is the first to match. It expects done, and not timeout, after exactly MAX_POLLS reads. A neighbouring case stays busy for MAX_POLLS reads and must give timeout. Random pages with busy lengths spread across and beyond the limit exercise both outcomes.

// File: rtl/epp_pkg.sv
// Package: shared sequencer state encoding for the EEPROM page poller.
// Assumes nothing beyond a synthesizable enum.
package epp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a request
        ST_FETCH,  // waiting for next data byte
        ST_SETUP,  // address/data driven, WE still high
        ST_WLOW,   // WE pulse low
        ST_WHOLD,  // WE back high, data still driven
        ST_TURN,   // bus turnaround before first read
        ST_READ,   // poll read, CE/OE low
        ST_RGAP    // idle clock between poll reads
    } epp_state_e;

endpackage

// File: rtl/epp_addr_gen.sv
// Address generator: loads a base address and steps the in-page offset,
// wrapping within the page so the page bits never change.
// Assumes PAGE_BYTES is a power of two smaller than 2**ADDR_W.
module epp_addr_gen #(
    parameter int ADDR_W     = 15,
    parameter int PAGE_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] addr
);
    localparam int PW = $clog2(PAGE_BYTES);

    logic [ADDR_W-1:0] addr_q;

    // Hold the current byte address; offset increments modulo page size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= base;
        end else if (step) begin
            addr_q <= {addr_q[ADDR_W-1:PW], addr_q[PW-1:0] + PW'(1)};
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/epp_poll_ctr.sv
// Poll counter: counts completed poll reads and flags when the read now
// finishing is the last one allowed.
// Assumes MAX_POLLS >= 1.
module epp_poll_ctr #(
    parameter int MAX_POLLS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(MAX_POLLS + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

    logic [CW-1:0] cnt_q;

    // Count reads since the polling phase began.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign at_limit = (cnt_q == LAST);
endmodule

// File: rtl/epp_seq.sv
// Sequencer: accepts the request, fetches bytes, shapes each write pulse,
// then runs the bit-7 poll loop and reports done or timeout.
// Assumes the byte source keeps up with the device's byte-load window.
module epp_seq
    import epp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int LEN_W       = 7,
    parameter int WE_LOW_CLKS = 4,
    parameter int READ_CLKS   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [LEN_W-1:0]  start_len_m1,
    input  logic              byte_valid,
    output logic              byte_ready,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              rd_msb,
    input  logic              poll_last,
    output logic              load_addr,
    output logic              step_addr,
    output logic              clr_polls,
    output logic              inc_polls,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out,
    output logic              done,
    output logic              timeout_err
);
    localparam int MAXT = (WE_LOW_CLKS > READ_CLKS) ? WE_LOW_CLKS : READ_CLKS;
    localparam int TW   = $clog2(MAXT + 1);
    localparam logic [TW-1:0] WE_INIT = TW'(WE_LOW_CLKS - 1);
    localparam logic [TW-1:0] RD_INIT = TW'(READ_CLKS - 1);

    epp_state_e        state_q;
    logic [TW-1:0]     timer_q;
    logic [LEN_W-1:0]  left_q;
    logic [DATA_W-1:0] data_q;
    logic              done_q, to_q;
    logic              rd_end, match;

    assign rd_end = (state_q == ST_READ) && (timer_q == '0);
    assign match  = (rd_msb == data_q[DATA_W-1]);

    // Main state machine: write pulses, turnaround and poll loop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            timer_q <= '0;
            left_q  <= '0;
            data_q  <= '0;
            done_q  <= 1'b0;
            to_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            to_q   <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_valid) begin
                    left_q  <= start_len_m1;
                    state_q <= ST_FETCH;
                end
                ST_FETCH: if (byte_valid) begin
                    data_q  <= byte_data;
                    state_q <= ST_SETUP;
                end
                ST_SETUP: begin
                    timer_q <= WE_INIT;
                    state_q <= ST_WLOW;
                end
                ST_WLOW: begin
                    if (timer_q == '0) state_q <= ST_WHOLD;
                    else               timer_q <= timer_q - TW'(1);
                end
                ST_WHOLD: begin
                    if (left_q == '0) begin
                        state_q <= ST_TURN;
                    end else begin
                        left_q  <= left_q - LEN_W'(1);
                        state_q <= ST_FETCH;
                    end
                end
                ST_TURN, ST_RGAP: begin
                    timer_q <= RD_INIT;
                    state_q <= ST_READ;
                end
                ST_READ: begin
                    if (timer_q != '0) begin
                        timer_q <= timer_q - TW'(1);
                    end else if (match) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (poll_last) begin
                        to_q    <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_RGAP;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Handshake, counter controls and memory strobes decoded from state.
    always_comb begin
        start_ready = (state_q == ST_IDLE);
        byte_ready  = (state_q == ST_FETCH);
        load_addr   = (state_q == ST_IDLE) && start_valid;
        step_addr   = (state_q == ST_WHOLD) && (left_q != '0);
        clr_polls   = (state_q == ST_TURN);
        inc_polls   = rd_end;
        dq_oe       = (state_q == ST_SETUP) || (state_q == ST_WLOW) ||
                      (state_q == ST_WHOLD);
        ce_n        = !(dq_oe || (state_q == ST_READ));
        we_n        = (state_q != ST_WLOW);
        oe_n        = (state_q != ST_READ);
    end

    assign dq_out      = data_q;
    assign done        = done_q;
    assign timeout_err = to_q;
endmodule

// File: rtl/eeprom_page_poller.sv
// Top: parallel EEPROM page writer with bit-7 completion polling.
// Joins the sequencer, the in-page address generator and the poll counter.
// Assumes the pad ring merges mem_dq_out/mem_dq_oe/mem_dq_in into one bus.
module eeprom_page_poller #(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 128,
    parameter int WE_LOW_CLKS = 4,
    parameter int READ_CLKS   = 2,
    parameter int MAX_POLLS   = 1000,
    localparam int LEN_W      = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len_m1,
    input  logic              byte_valid,
    output logic              byte_ready,
    input  logic [DATA_W-1:0] byte_data,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              done,
    output logic              timeout_err
);
    logic load_addr, step_addr, clr_polls, inc_polls, poll_last;
    logic unused_rd_bits;

    assign unused_rd_bits = ^mem_dq_in[DATA_W-2:0];

    epp_seq #(
        .DATA_W(DATA_W), .LEN_W(LEN_W),
        .WE_LOW_CLKS(WE_LOW_CLKS), .READ_CLKS(READ_CLKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_ready(start_ready),
        .start_len_m1(start_len_m1),
        .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
        .rd_msb(mem_dq_in[DATA_W-1]), .poll_last(poll_last),
        .load_addr(load_addr), .step_addr(step_addr),
        .clr_polls(clr_polls), .inc_polls(inc_polls),
        .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n),
        .dq_oe(mem_dq_oe), .dq_out(mem_dq_out),
        .done(done), .timeout_err(timeout_err)
    );

    epp_addr_gen #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load_addr), .step(step_addr),
        .base(start_addr), .addr(mem_addr)
    );

    epp_poll_ctr #(.MAX_POLLS(MAX_POLLS)) u_polls (
        .clk(clk), .rst_n(rst_n), .clr(clr_polls), .inc(inc_polls),
        .at_limit(poll_last)
    );
endmodule

// File: rtl/epp_poller_chk.sv
// Checker: protocol properties of the EEPROM page poller, bound to the top.
module epp_poller_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_ready,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe,
    input logic              done,
    input logic              timeout_err
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_we_fall_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_out) && $past(mem_dq_oe)));

    p_we_rise_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_addr) && $stable(mem_dq_out)));

    p_bus_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> (!$past(mem_dq_oe) && $past(mem_ce_n)));

    p_read_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n && !mem_dq_oe));

    p_read_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (start_ready && !timeout_err));

    p_timeout_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> start_ready);
endmodule

bind eeprom_page_poller epp_poller_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_ready(start_ready),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .done(done), .timeout_err(timeout_err)
);

// File: tb/eeprom_page_poller_bench.sv
module eeprom_page_poller_bench;
    localparam int AW = 15, DW = 8, PB = 128, WEL = 3, RDC = 2, MAXP = 6, LW = 7;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_valid = 1'b0, byte_valid = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [LW-1:0] start_len_m1 = '0;
    logic [DW-1:0] byte_data = '0;
    logic start_ready, byte_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, done, timeout_err;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    always #2 clk = ~clk;

    eeprom_page_poller #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WE_LOW_CLKS(WEL),
                         .READ_CLKS(RDC), .MAX_POLLS(MAXP)) u_eeprom_page_poller (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
        .start_addr(start_addr), .start_len_m1(start_len_m1), .byte_valid(byte_valid),
        .byte_ready(byte_ready), .byte_data(byte_data), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
        .done(done), .timeout_err(timeout_err));

    // EEPROM model and bus monitor
    logic [DW-1:0] mem [0:511];
    logic [AW-1:0] log_addr [0:PB-1];
    logic [DW-1:0] log_data [0:PB-1];
    int n_wr, n_rd, busy_cfg, busy_left, we_run, we_bad, bus_viol, rd_addr_bad, done_cnt, to_cnt;
    logic tog, prev_we_n = 1'b1, prev_oe_n = 1'b1, prev_dq_oe = 1'b0, prev_ce_n = 1'b1;
    logic [AW-1:0] exp_last;
    int checks = 0, errors = 0;

    assign mem_dq_in = (!mem_ce_n && !mem_oe_n) ?
        ((busy_left > 0) ? {~mem[mem_addr[8:0]][7], tog, mem[mem_addr[8:0]][5:0]}
                         : mem[mem_addr[8:0]]) : '0;

    always @(negedge clk) begin
        if (!mem_we_n) we_run++;
        if (mem_we_n && !prev_we_n) begin
            if (we_run != WEL || mem_ce_n) we_bad++;
            we_run = 0;
            if (n_wr < PB) begin
                log_addr[n_wr] = mem_addr;
                log_data[n_wr] = mem_dq_out;
            end
            n_wr++;
            mem[mem_addr[8:0]] = mem_dq_out;
            busy_left = busy_cfg;
        end
        if (!mem_oe_n && prev_oe_n) begin
            n_rd++;
            if (mem_addr != exp_last) rd_addr_bad++;
            if (prev_dq_oe || !prev_ce_n) bus_viol++;
        end
        if (mem_oe_n && !prev_oe_n) begin
            if (busy_left > 0) busy_left--;
            tog = ~tog;
        end
        if (mem_dq_oe && !mem_oe_n) bus_viol++;
        if (done) done_cnt++;
        if (timeout_err) to_cnt++;
        prev_we_n = mem_we_n; prev_oe_n = mem_oe_n; prev_dq_oe = mem_dq_oe; prev_ce_n = mem_ce_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] base, input int i);
        return {base[AW-1:7], 7'(int'(base[6:0]) + i)};
    endfunction

    // One page write plus polling; checks writes, reads and outcome.
    task automatic run_page(input logic [AW-1:0] base, input int len, input int busy, input bit poke);
        logic [DW-1:0] d [0:PB-1];
        int d0, t0, guard, a_bad, dt_bad, exp_reads, poke_bad;
        bit exp_done;
        for (int i = 0; i < len; i++) d[i] = 8'($urandom);
        n_wr = 0; n_rd = 0; we_bad = 0; bus_viol = 0; rd_addr_bad = 0; poke_bad = 0;
        busy_cfg = busy; exp_last = exp_addr(base, len - 1);
        d0 = done_cnt; t0 = to_cnt;
        start_addr = base; start_len_m1 = LW'(len - 1); start_valid = 1'b1;
        while (!start_ready) @(negedge clk);
        @(negedge clk);
        start_valid = 1'b0;
        for (int i = 0; i < len; i++) begin
            repeat ($urandom % 3) @(negedge clk);
            if (poke) begin
                start_valid = 1'b1; start_addr = 15'h7FFF; start_len_m1 = '0;
                if (start_ready) poke_bad++;
            end
            byte_valid = 1'b1; byte_data = d[i];
            while (!byte_ready) @(negedge clk);
            @(negedge clk);
            byte_valid = 1'b0;
        end
        start_valid = 1'b0;
        guard = 0;
        while (done_cnt == d0 && to_cnt == t0 && guard < 5000) begin
            @(negedge clk); guard++;
        end
        repeat (4) @(negedge clk);
        a_bad = 0; dt_bad = 0;
        for (int i = 0; i < len && i < n_wr; i++) begin
            if (log_addr[i] != exp_addr(base, i)) a_bad++;
            if (log_data[i] != d[i]) dt_bad++;
        end
        exp_done  = (busy + 1 <= MAXP);
        exp_reads = exp_done ? busy + 1 : MAXP;
        chk(n_wr == len, "R3 byte count", n_wr, len);
        chk(a_bad == 0, "R3 in-page addresses", a_bad, 0);
        chk(dt_bad == 0, "R4 data written", dt_bad, 0);
        chk(we_bad == 0, "R4 WE pulse width", we_bad, 0);
        chk(bus_viol == 0, "R5 bus turnaround", bus_viol, 0);
        chk(rd_addr_bad == 0, "R6 poll address", rd_addr_bad, 0);
        chk(n_rd == exp_reads, exp_done ? "R7 read count" : "R8 read count", n_rd, exp_reads);
        chk((done_cnt - d0) == int'(exp_done), "R7 done pulse", done_cnt - d0, int'(exp_done));
        chk((to_cnt - t0) == int'(!exp_done), "R8 timeout pulse", to_cnt - t0, int'(!exp_done));
        chk(start_ready == 1'b1, "R2 idle after sequence", int'(start_ready), 1);
        if (poke) begin
            chk(poke_bad == 0, "R2 start refused while busy", poke_bad, 0);
            chk(n_wr == len, "R2 no extra page from ignored start", n_wr, len);
        end
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 512; i++) mem[i] = '0;
        n_wr = 0; n_rd = 0; busy_cfg = 0; busy_left = 0; we_run = 0; tog = 1'b0;
        done_cnt = 0; to_cnt = 0; exp_last = '0;
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes high in reset", int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_dq_oe && start_ready && !done && !timeout_err, "R1 idle after reset",
            int'({mem_dq_oe, start_ready, done, timeout_err}), 4);
        // Directed corners
        run_page(15'h0000, 1, 0, 1'b0);          // single byte, ready at once
        run_page(15'h157E, 4, 2, 1'b0);          // offset wraps within page
        run_page(15'h1280, PB, 3, 1'b0);         // full page
        run_page(15'h0A05, 3, MAXP - 1, 1'b0);   // match on the last allowed read
        run_page(15'h0A05, 3, MAXP, 1'b0);       // limit reached: timeout
        run_page(15'h3300, 5, 1, 1'b1);          // start poked while busy
        // Random pages
        for (int k = 0; k < 10; k++)
            run_page(15'($urandom), 1 + ($urandom % PB), $urandom % (MAXP + 2), 1'($urandom % 2));
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule